// File: doc/BRIEF.md
# Filtered Phase-Lock Monitor

This block watches a reference pulse train and the divided feedback pulse train of a phase-locked loop. It decides from them whether the loop is locked. Both inputs are sampled by a fast clock. Only one reference period in every sixty-four is examined. In that period the block measures, in sample-clock cycles, how far the reference rising edge is from the nearest feedback rising edge. It works whichever of the two edges comes first.

Each examined period gives an in-window or out-of-window verdict against a programmable threshold. A small filter turns these verdicts into a lock flag. The flag is raised only after a run of four in-window verdicts in a row. It is cleared by a single out-of-window verdict.

An enable input forces the output low without disturbing the filter. A loop controller can therefore read a clean lock indication, and glitches between examined periods cannot reach it.

Top module: `phase_lock_monitor`

## Requirements
- R1: While reset is asserted and after its release, `lockOut` is 0 until lock has been reached.
- R2: A rising edge is a low-to-high change of an input between two consecutive clock samples. Rising edges of `refIn` are counted from reset. Only every 64th one (the 64th, 128th, ...) starts a comparison. Feedback behaviour in all other reference periods has no effect on `lockOut`.
- R3: The phase error is the distance in clock cycles from the examined reference edge to the nearest feedback edge. A leading candidate is a feedback edge seen since the previous reference edge. A trailing candidate is a feedback edge seen before the next reference edge. A coincident edge gives an error of 0.
- R4: A comparison is in-window when the phase error is less than or equal to `threshold`, and out-of-window otherwise.
- R5: `lockOut` rises after the fourth consecutive in-window comparison. It stays high while further comparisons are in-window.
- R6: A single out-of-window comparison drives `lockOut` low and restarts the count. Four new consecutive in-window comparisons are then needed to raise it again.
- R7: If no feedback edge occurs in the reference period before or the one after the examined reference edge, the comparison is out-of-window.
- R8: While `ldEnable` is 0, `lockOut` is 0 in the same cycle. Raising `ldEnable` again shows the filter state, which the disable did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Reference pulse, synchronous to clk |
| fbIn | input | 1 | Divided feedback pulse, synchronous to clk |
| ldEnable | input | 1 | Lock output enable; 0 holds the output low |
| threshold | input | CNT_W | Largest phase error, in clock cycles, still counted as in-window |
| lockOut | output | 1 | Filtered lock indication |

## Verification
The bench runs a near-exhaustive sweep in which the feedback edge sits from three cycles ahead to three cycles behind the reference edge. The sweep covers every threshold from 0 to 3. This tells leading and trailing measurements apart and pins down the boundary where the error equals the threshold. Before each sweep point, a comparison with no feedback at all clears the filter. The four following in-window comparisons then show that exactly the fourth one raises the lock.

Further patterns change only the examined period, or only the skipped periods. They show that decimation ignores the skipped periods and that one bad comparison drops lock at once. Toggling the enable while locked shows that the filter state survives the disable.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic passHit;
    logic failHit;
  } plmStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic measureEdge;
    logic leadIn;
    logic lagIn;
    logic lagOver;
  } plmStatus_t;

endpackage

// File: rtl/plm_datapath.sv
module plm_datapath
  import plm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DECIM    = 64,
  parameter int LOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic [CNT_W-1:0] threshold,
  input  plmStrobe_t       stb,
  output plmStatus_t       stat,
  output logic             lockQ
);

  localparam int DEC_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECIM - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_PRE  = RUN_W'(LOCK_RUN - 1);

  logic refPrev, fbPrev;
  logic refRise, fbRise;
  logic [DEC_W-1:0] refCnt;
  logic [CNT_W-1:0] fbAge;
  logic [CNT_W-1:0] lagCnt;
  logic             fbSeen;
  logic [CNT_W-1:0] leadErr;
  logic             leadValid;
  logic [RUN_W-1:0] runCnt;

  // edge detection on sampled inputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
    end
  end

  assign refRise = refIn & ~refPrev;
  assign fbRise  = fbIn & ~fbPrev;

  // decimation: count reference edges modulo DECIM
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (refRise) begin
      refCnt <= (refCnt == DEC_LAST) ? '0 : refCnt + 1'b1;
    end
  end

  // age of the last feedback edge (leading candidate)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fbAge <= CNT_MAX;
    end else if (fbRise) begin
      fbAge <= CNT_W'(1);
    end else if (fbAge != CNT_MAX) begin
      fbAge <= fbAge + 1'b1;
    end
  end

  // a feedback edge seen since the previous reference edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fbSeen <= 1'b0;
    end else if (refRise) begin
      fbSeen <= 1'b0;
    end else if (fbRise) begin
      fbSeen <= 1'b1;
    end
  end

  // cycles since the last reference edge (trailing candidate)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lagCnt <= CNT_MAX;
    end else if (refRise) begin
      lagCnt <= CNT_W'(1);
    end else if (lagCnt != CNT_MAX) begin
      lagCnt <= lagCnt + 1'b1;
    end
  end

  assign leadErr   = fbRise ? '0 : fbAge;
  assign leadValid = fbRise | fbSeen;

  always_comb begin
    stat.measureEdge = refRise && (refCnt == DEC_LAST);
    stat.leadIn      = leadValid && (leadErr <= threshold);
    stat.lagIn       = fbRise && (lagCnt <= threshold);
    stat.lagOver     = refRise || (lagCnt > threshold);
  end

  // verdict filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
      lockQ  <= 1'b0;
    end else if (stb.failHit) begin
      runCnt <= '0;
      lockQ  <= 1'b0;
    end else if (stb.passHit) begin
      if (runCnt != RUN_FULL) runCnt <= runCnt + 1'b1;
      if (runCnt >= RUN_PRE) lockQ <= 1'b1;
    end
  end

endmodule

// File: rtl/plm_control.sv
module plm_control
  import plm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  plmStatus_t stat,
  output plmStrobe_t stb
);

  typedef enum logic {WATCH, LAGWAIT} plmState_e;

  plmState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= WATCH;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb.passHit = 1'b0;
    stb.failHit = 1'b0;
    case (state)
      WATCH: begin
        if (stat.measureEdge) begin
          if (stat.leadIn) stb.passHit = 1'b1;
          else             nextState   = LAGWAIT;
        end
      end
      LAGWAIT: begin
        if (stat.lagIn) begin
          stb.passHit = 1'b1;
          nextState   = WATCH;
        end else if (stat.lagOver) begin
          stb.failHit = 1'b1;
          nextState   = WATCH;
        end
      end
      default: nextState = WATCH;
    endcase
  end

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import plm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DECIM    = 64,
  parameter int LOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic             ldEnable,
  input  logic [CNT_W-1:0] threshold,
  output logic             lockOut
);

  plmStrobe_t ctlStb;
  plmStatus_t dpStat;
  logic       lockQ;

  plm_datapath #(
    .CNT_W   (CNT_W),
    .DECIM   (DECIM),
    .LOCK_RUN(LOCK_RUN)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .refIn    (refIn),
    .fbIn     (fbIn),
    .threshold(threshold),
    .stb      (ctlStb),
    .stat     (dpStat),
    .lockQ    (lockQ)
  );

  plm_control u_control (
    .clk (clk),
    .rstN(rstN),
    .stat(dpStat),
    .stb (ctlStb)
  );

  assign lockOut = lockQ & ldEnable;

endmodule

// File: rtl/plm_checker.sv
module plm_checker (
  input logic clk,
  input logic rstN,
  input logic ldEnable,
  input logic lockOut,
  input logic lockQ,
  input logic passHit,
  input logic failHit,
  input logic measureEdge
);

  // R4
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(passHit && failHit));

  // R5
  lock_rise_after_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(passHit));

  // R6
  fail_drops_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    failHit |=> !lockQ);

  // R2
  lock_steady_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(passHit || failHit) |=> $stable(lockQ));

  // R8
  output_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> (ldEnable && ($rose(ldEnable) || $past(passHit))));

  // R2
  measure_no_pass_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (measureEdge && !passHit) |=> $stable(lockQ));

endmodule

bind phase_lock_monitor plm_checker u_plmChk (
  .clk        (clk),
  .rstN       (rstN),
  .ldEnable   (ldEnable),
  .lockOut    (lockOut),
  .lockQ      (lockQ),
  .passHit    (ctlStb.passHit),
  .failHit    (ctlStb.failHit),
  .measureEdge(dpStat.measureEdge)
);

// File: tb/phase_lock_monitor_bench.sv
module phase_lock_monitor_bench;

  localparam int CNT_W = 8;
  localparam int PER   = 10;
  localparam int BASE  = 4;

  logic clk = 1'b0;
  logic rstN;
  logic refIn, fbIn, ldEnable;
  logic [CNT_W-1:0] threshold;
  logic lockOut;

  int checks = 0;
  int fails  = 0;
  int runLen = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  phase_lock_monitor #(.CNT_W(CNT_W), .DECIM(64), .LOCK_RUN(4)) u_phase_lock_monitor (
    .clk      (clk),
    .rstN     (rstN),
    .refIn    (refIn),
    .fbIn     (fbIn),
    .ldEnable (ldEnable),
    .threshold(threshold),
    .lockOut  (lockOut)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: lockOut=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // one reference period; feedback offset d cycles from the reference edge
  task automatic onePeriod(input int d, input bit fbOn);
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      refIn = (c == BASE) || (c == BASE + 1);
      fbIn  = fbOn && ((c == BASE + d) || (c == BASE + 1 + d));
    end
  endtask

  // 64 periods: 63 skipped, then the examined one
  task automatic block(input int dLast, input bit fbLast, input bit fbOthers, input string req);
    bit pass;
    for (int p = 0; p < 63; p++) onePeriod(0, fbOthers);
    onePeriod(dLast, fbLast);
    pass = fbLast && ((dLast < 0 ? -dLast : dLast) <= int'(threshold));
    runLen = pass ? runLen + 1 : 0;
    check(lockOut, (runLen >= 4) && ldEnable, req);
  endtask

  initial begin
    rstN = 1'b0; refIn = 1'b0; fbIn = 1'b0; ldEnable = 1'b1; threshold = '0;
    repeat (3) @(negedge clk);
    check(lockOut, 1'b0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(lockOut, 1'b0, "R1 after reset");

    // sweep threshold and offset (R3, R4, R5, R7)
    for (int t = 0; t < 4; t++) begin
      for (int d = -3; d <= 3; d++) begin
        threshold = CNT_W'(t);
        block(0, 1'b0, 1'b1, "R7 missing feedback");
        for (int k = 0; k < 4; k++) block(d, 1'b1, 1'b1, "R3 R4 R5 sweep");
      end
    end

    threshold = CNT_W'(2);
    block(0, 1'b0, 1'b1, "R7 clear");
    for (int k = 0; k < 4; k++) block(-1, 1'b1, 1'b1, "R5 build lock");
    block(2, 1'b1, 1'b1, "R5 stays locked");
    block(1, 1'b1, 1'b0, "R2 skipped periods ignored");
    @(negedge clk); ldEnable = 1'b0; #1;
    check(lockOut, 1'b0, "R8 disabled");
    @(negedge clk); ldEnable = 1'b1; #1;
    check(lockOut, 1'b1, "R8 re-enabled");
    block(3, 1'b1, 1'b1, "R6 single bad drops lock");
    for (int k = 0; k < 3; k++) block(0, 1'b1, 1'b1, "R6 count restarted");
    block(0, 1'b1, 1'b1, "R6 relock on fourth");
    @(negedge clk); ldEnable = 1'b0; #1;
    check(lockOut, 1'b0, "R8 disabled again");
    block(0, 1'b1, 1'b1, "R8 filter runs while disabled");
    @(negedge clk); ldEnable = 1'b1; #1;
    check(lockOut, 1'b1, "R8 state kept");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule